// File: doc/BRIEF.md
# USB Transceiver Link-Side Control Register Bank

This block holds the two link-facing control registers of a USB transceiver: one that picks the speed, termination, encoding style, suspend state and core reset, and one that selects alternative interfaces and indicator handling. Each register can be reached at three neighbouring addresses. The first address replaces the whole value. The second address ORs a one-mask into it. The third address clears the bits marked by a one-mask. A read at any of the three addresses returns the current value.

Two bits clear themselves. Writing 1 to the reset bit starts a fixed-length sequence. During that sequence the block drives the bus-direction output high and pulses a core-reset output. When the sequence ends it drops direction, clears the bit and requests a receive-command update. The register bank itself is never reset by this sequence. Clearing the suspend bit puts the transceiver in low power. The link brings it back by raising the stop input, and the suspend bit then returns to 1 without any write.

Top module: `phy_ctrl_regs`

## Requirements
- R1: After synchronous reset, the speed/mode register (set A, addresses 04h..06h) reads 41h, the interface register (set B, addresses 07h..09h) reads 00h, and `dir`, `core_rst`, `rxcmd_req` and `lowpwr` are 0.
- R2: A write at the first address of a set (04h or 07h) replaces the register with the write data masked by its writable bits. Set A: bit 7 reserved. Set B: bits 2 and 4 reserved. Reserved bits always read 0. Set A fields: bit 6 suspend (active low), bit 5 core reset, bits 4:3 encoding mode, bit 2 termination, bits 1:0 speed.
- R3: A write at the second address (05h or 08h) sets every writable bit that is 1 in the write data and leaves the others unchanged.
- R4: A write at the third address (06h or 09h) clears every writable bit that is 1 in the write data and leaves the others unchanged.
- R5: `rd_data` shows, one clock after `acc_addr` is presented, the value of the register that the address selects, at any of its three aliases. Addresses outside 04h..09h read 00h, and writes to them change nothing.
- R6: Once bit 5 of set A holds 1, `dir` rises on the next clock. It stays high until the 8th clock edge after the accepted write, so it is high for 7 cycles.
- R7: `core_rst` rises together with `dir` and stays high for 4 cycles.
- R8: When `dir` falls, bit 5 of set A reads 0 and `rxcmd_req` is high for exactly that one cycle.
- R9: While `dir` is high, writes are ignored and `rd_data` returns 00h.
- R10: When bit 6 of set A is cleared, `lowpwr` rises one clock later. A clock edge with `stp` high while bit 6 is 0 sets bit 6 again, and `lowpwr` falls on the following edge.
- R11: `stp` has no effect on either register or on `lowpwr` while bit 6 of set A is 1.
- R12: The core-reset sequence leaves every other bit of both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_we | input | 1 | Register write strobe |
| acc_addr | input | ADDR_W | Register address, used for reads and writes |
| acc_wdata | input | 8 | Write data or bit mask |
| rd_data | output | 8 | Registered read data, one clock behind `acc_addr` |
| stp | input | 1 | Stop from the link; wakes the transceiver from low power |
| dir | output | 1 | Bus direction, high during core reset |
| core_rst | output | 1 | Reset pulse to the transceiver digital core |
| rxcmd_req | output | 1 | One-cycle request to send a receive-command update |
| lowpwr | output | 1 | Low-power mode active |
| func_ctrl | output | 8 | Current value of register set A |
| intf_ctrl | output | 8 | Current value of register set B |

## Verification
The assertions assume the link respects the direction handshake. That means no write of a new reset request lands in the cycle that starts the sequence, and `stp` is not raised in the same cycle as a write that touches the suspend bit. They also assume the interface mode bits of set B are not set in combination in a way that matters to downstream logic, since that case has no defined meaning. The stimulus keeps the write strobe low while it waits out the reset sequence. It only tries a write during that window on purpose, to set B, to show that the write is dropped. It also pulses `stp` only in cycles with no write.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;

  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 2;
  localparam int ALIASES  = 3;

  localparam int FUNC_IDX = 0;
  localparam int INTF_IDX = 1;

  localparam int SUSP_BIT = 6;
  localparam int CRST_BIT = 5;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } alias_op_e;

  function automatic int reg_base(input int idx);
    return (idx == FUNC_IDX) ? 4 : 7;
  endfunction

  function automatic logic [DATA_W-1:0] reg_reset(input int idx);
    return (idx == FUNC_IDX) ? 8'h41 : 8'h00;
  endfunction

  function automatic logic [DATA_W-1:0] reg_wmask(input int idx);
    return (idx == FUNC_IDX) ? 8'h7F : 8'hEB;
  endfunction

endpackage

// File: rtl/phyreg_decode.sv
module phyreg_decode
  import phyreg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        we,
  input  logic                        blocked,
  output logic [NUM_REGS-1:0]         hit,
  output logic [NUM_REGS-1:0]         wr_en,
  output alias_op_e [NUM_REGS-1:0]    op
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(reg_base(i));
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(reg_base(i) + ALIASES - 1);
    logic [ADDR_W-1:0] off;

    assign hit[i]   = (addr >= LO) && (addr <= HI);
    assign off      = addr - LO;
    assign wr_en[i] = we && hit[i] && !blocked;

    always_comb begin
      if (!hit[i]) begin
        op[i] = OP_NONE;
      end else begin
        case (off[1:0])
          2'd0:    op[i] = OP_WRITE;
          2'd1:    op[i] = OP_SET;
          2'd2:    op[i] = OP_CLEAR;
          default: op[i] = OP_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/phyreg_cell.sv
module phyreg_cell
  import phyreg_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL = '0,
  parameter logic [DATA_W-1:0] WMASK   = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  alias_op_e         op,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_set,
  input  logic [DATA_W-1:0] hw_clr,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] sw_next;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    sw_next = q;
    if (wr_en) begin
      case (op)
        OP_WRITE: sw_next = wdata;
        OP_SET:   sw_next = q | wdata;
        OP_CLEAR: sw_next = q & ~wdata;
        default:  sw_next = q;
      endcase
    end
    nxt = ((sw_next | hw_set) & ~hw_clr) & WMASK;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL & WMASK;
    else     q <= nxt;
  end

  // Reserved bits never become visible.
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (q & ~WMASK) == '0);

endmodule

// File: rtl/phyreg_seq.sv
module phyreg_seq
  import phyreg_pkg::*;
#(
  parameter int RST_CYCLES  = 8,
  parameter int CORE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              crst_bit,
  input  logic              susp_bit,
  input  logic              stp,
  output logic              dir,
  output logic              core_rst,
  output logic              rxcmd_req,
  output logic              lowpwr,
  output logic [DATA_W-1:0] hw_set,
  output logic [DATA_W-1:0] hw_clr
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic             done;
  logic             wake;

  assign done = dir && (cnt == CNT_W'(RST_CYCLES - 1));
  assign wake = stp && !susp_bit;

  always_comb begin
    hw_set = '0;
    hw_clr = '0;
    hw_set[SUSP_BIT] = wake;
    hw_clr[CRST_BIT] = done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir       <= 1'b0;
      core_rst  <= 1'b0;
      rxcmd_req <= 1'b0;
      lowpwr    <= 1'b0;
      cnt       <= '0;
    end else begin
      rxcmd_req <= 1'b0;
      lowpwr    <= !susp_bit;
      if (!dir && crst_bit) begin
        dir      <= 1'b1;
        core_rst <= 1'b1;
        cnt      <= CNT_W'(1);
      end else if (dir) begin
        cnt <= cnt + CNT_W'(1);
        if (cnt == CNT_W'(CORE_CYCLES)) core_rst <= 1'b0;
        if (done) begin
          dir       <= 1'b0;
          core_rst  <= 1'b0;
          rxcmd_req <= 1'b1;
          cnt       <= '0;
        end
      end
    end
  end

  p_dir_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(dir) |-> $past(crst_bit));

  p_core_in_dir_r7: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> dir);

  p_rxcmd_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
    rxcmd_req |-> (!dir && $past(dir)));

  p_rxcmd_single_r8: assert property (@(posedge clk) disable iff (rst)
    rxcmd_req |=> !rxcmd_req);

  p_wake_sets_r10: assert property (@(posedge clk) disable iff (rst)
    (stp && !susp_bit) |=> susp_bit);

endmodule

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
  import phyreg_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int RST_CYCLES  = 8,
  parameter int CORE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        rd_data,
  input  logic              stp,
  output logic              dir,
  output logic              core_rst,
  output logic              rxcmd_req,
  output logic              lowpwr,
  output logic [7:0]        func_ctrl,
  output logic [7:0]        intf_ctrl
);

  logic [NUM_REGS-1:0]           hit;
  logic [NUM_REGS-1:0]           wr_en;
  alias_op_e [NUM_REGS-1:0]      op;
  logic [NUM_REGS-1:0][DATA_W-1:0] q;
  logic [DATA_W-1:0]             seq_set;
  logic [DATA_W-1:0]             seq_clr;
  logic [DATA_W-1:0]             rd_mux;

  phyreg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr    (acc_addr),
    .we      (acc_we),
    .blocked (dir),
    .hit     (hit),
    .wr_en   (wr_en),
    .op      (op)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] hs;
    logic [DATA_W-1:0] hc;
    if (i == FUNC_IDX) begin : g_hw
      assign hs = seq_set;
      assign hc = seq_clr;
    end else begin : g_sw
      assign hs = '0;
      assign hc = '0;
    end
    phyreg_cell #(
      .RST_VAL (reg_reset(i)),
      .WMASK   (reg_wmask(i))
    ) u_cell (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en[i]),
      .op     (op[i]),
      .wdata  (acc_wdata),
      .hw_set (hs),
      .hw_clr (hc),
      .q      (q[i])
    );
  end

  phyreg_seq #(
    .RST_CYCLES  (RST_CYCLES),
    .CORE_CYCLES (CORE_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .crst_bit  (q[FUNC_IDX][CRST_BIT]),
    .susp_bit  (q[FUNC_IDX][SUSP_BIT]),
    .stp       (stp),
    .dir       (dir),
    .core_rst  (core_rst),
    .rxcmd_req (rxcmd_req),
    .lowpwr    (lowpwr),
    .hw_set    (seq_set),
    .hw_clr    (seq_clr)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit[i]) rd_mux = q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      rd_data <= '0;
    else if (dir) rd_data <= '0;
    else          rd_data <= rd_mux;
  end

  assign func_ctrl = q[FUNC_IDX];
  assign intf_ctrl = q[INTF_IDX];

  // Writes during the direction handshake leave set B untouched.
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (dir && acc_we) |=> $stable(intf_ctrl));

  // The reset sequence touches no bit of set A other than bit 5.
  p_keep_bits_r12: assert property (@(posedge clk) disable iff (rst)
    (dir && !acc_we && !stp) |=> ((func_ctrl & 8'hDF) == ($past(func_ctrl) & 8'hDF)));

endmodule

// File: tb/phy_ctrl_regs_bench.sv
`timescale 1ns/1ps
module phy_ctrl_regs_bench;

  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              acc_we = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [7:0]        acc_wdata = '0;
  logic [7:0]        rd_data;
  logic              stp = 1'b0;
  logic              dir, core_rst, rxcmd_req, lowpwr;
  logic [7:0]        func_ctrl, intf_ctrl;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    int        due;
    logic [7:0] exp;
    string     tag;
  } rd_item_t;

  rd_item_t sb_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phy_ctrl_regs #(.ADDR_W(ADDR_W)) u_phy_ctrl_regs (
    .clk(clk), .rst(rst), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .stp(stp), .dir(dir),
    .core_rst(core_rst), .rxcmd_req(rxcmd_req), .lowpwr(lowpwr),
    .func_ctrl(func_ctrl), .intf_ctrl(intf_ctrl)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Monitor: compares read results against the scoreboard queue.
  always @(posedge clk) begin
    #1;
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      rd_item_t it;
      it = sb_q.pop_front();
      check(it.tag, rd_data, it.exp);
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    acc_addr = a;
    it.due = cyc + 1; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 func_ctrl", func_ctrl, 8'h41);
    check("R1 intf_ctrl", intf_ctrl, 8'h00);
    check("R1 dir/core/rxcmd/lowpwr", {4'h0, dir, core_rst, rxcmd_req, lowpwr}, 8'h00);
    rd(6'h04, 8'h41, "R1 read A");
    rd(6'h07, 8'h00, "R1 read B");

    // R2 write alias, reserved bits masked
    wr(6'h04, 8'hC3);
    rd(6'h04, 8'h43, "R2 write A");
    wr(6'h07, 8'hFF);
    rd(6'h07, 8'hEB, "R2 write B reserved");
    // R3 set alias
    wr(6'h05, 8'h18);
    rd(6'h05, 8'h5B, "R3 set A");
    wr(6'h09, 8'h41);
    wr(6'h08, 8'h14);
    rd(6'h08, 8'hAA, "R3 set B reserved ignored");
    wr(6'h08, 8'h01);
    rd(6'h09, 8'hAB, "R3 set B");
    // R4 clear alias
    wr(6'h06, 8'h02);
    rd(6'h06, 8'h59, "R4 clear A");
    rd(6'h04, 8'h59, "R5 alias 04h");
    wr(6'h09, 8'h80);
    rd(6'h07, 8'h2B, "R4 clear B");
    // R5 out-of-range
    wr(6'h0A, 8'hFF);
    wr(6'h03, 8'hFF);
    rd(6'h0A, 8'h00, "R5 read 0Ah");
    rd(6'h03, 8'h00, "R5 read 03h");
    rd(6'h00, 8'h00, "R5 read 00h");
    drain();
    check("R5 A unchanged", func_ctrl, 8'h59);
    check("R5 B unchanged", intf_ctrl, 8'h2B);

    // R6..R9, R12 core reset sequence
    wr(6'h04, 8'h5A);
    drain();
    check("R6 dir low before", {7'h0, dir}, 8'h00);
    acc_we = 1'b1; acc_addr = 6'h05; acc_wdata = 8'h20;
    @(negedge clk);                // after edge E0
    acc_we = 1'b0;
    check("R6 dir low after E0", {7'h0, dir}, 8'h00);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);              // after edge Ek
      check("R6 dir high", {7'h0, dir}, 8'h01);
      check("R7 core_rst", {7'h0, core_rst}, (k <= 4) ? 8'h01 : 8'h00);
      check("R8 no rxcmd yet", {7'h0, rxcmd_req}, 8'h00);
      if (k == 2) begin
        acc_we = 1'b1; acc_addr = 6'h07; acc_wdata = 8'h00;
      end else if (k == 3) begin
        acc_we = 1'b0; acc_addr = 6'h04;
      end else if (k == 4) begin
        check("R9 read during dir", rd_data, 8'h00);
      end
    end
    @(negedge clk);                // after E8
    check("R6 dir fall", {7'h0, dir}, 8'h00);
    check("R8 rxcmd pulse", {7'h0, rxcmd_req}, 8'h01);
    check("R8 reset bit cleared", func_ctrl, 8'h5A);
    @(negedge clk);
    check("R8 rxcmd single", {7'h0, rxcmd_req}, 8'h00);
    check("R9 write ignored", intf_ctrl, 8'h2B);
    rd(6'h06, 8'h5A, "R12 A retained");
    rd(6'h08, 8'h2B, "R12 B retained");
    drain();

    // R10 low-power entry and exit
    wr(6'h06, 8'h40);
    check("R10 lowpwr lag", {7'h0, lowpwr}, 8'h00);
    @(negedge clk);
    check("R10 lowpwr on", {7'h0, lowpwr}, 8'h01);
    rd(6'h04, 8'h1A, "R10 bit6 cleared");
    drain();
    stp = 1'b1;
    @(negedge clk);
    stp = 1'b0;
    check("R10 bit6 restored", func_ctrl, 8'h5A);
    @(negedge clk);
    check("R10 lowpwr off", {7'h0, lowpwr}, 8'h00);

    // R11 stp with bit 6 already 1
    stp = 1'b1;
    repeat (2) @(negedge clk);
    stp = 1'b0;
    @(negedge clk);
    check("R11 lowpwr stays", {7'h0, lowpwr}, 8'h00);
    check("R11 A unchanged", func_ctrl, 8'h5A);
    check("R11 B unchanged", intf_ctrl, 8'h2B);
    rd(6'h05, 8'h5A, "R11 read A");
    drain();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule